// File: doc/BRIEF.md
# Scaled-Index Load Address Generator

This block forms the effective address for a family of 64-bit indexed loads whose index operand is scaled before the add. The index register value is shifted left by one more than a small shift field, so a 2-bit field gives scale factors of 2, 4, 8 or 16. The shifted index is added to a base, and the sum wraps modulo 2^XLEN. For the plain forms the base is the contents of the base register, or zero when the base register number is 0. For the write-back forms the base is always the register's contents.

For write-back forms the block also raises a register-file write request. The request carries the base register number and the computed address. The block checks whether the encoding is legal. A write-back form that names register 0 as its base is illegal. The sign-extending halfword write-back form is also illegal when its base and target register numbers match. An illegal form raises a flag and cancels the write request. All results are registered and appear one clock after the input strobe, together with a valid output.

Top module: `idx_scaled_agen`

## Requirements
- R1: The address output equals (index value << (shift field + 1)) + base, truncated to XLEN bits. A shift field of 0..3 gives a shift of 1..4 positions, and any overflow of the add is discarded.
- R2: For a plain form (`upd` = 0) whose base register number is 0, the base is zero and the base register value has no effect on the address.
- R3: For a write-back form (`upd` = 1), the base is the base register value, including when the base register number is 0.
- R4: A legal write-back form asserts `ra_we`, with `ra_waddr` equal to the base register number and `ra_wdata` equal to the address output.
- R5: A write-back form whose base register number is 0 asserts `bad_form`.
- R6: A write-back form asserts `bad_form` when `alg` = 1, `acc_size` = 1 (halfword) and the base and target register numbers are equal. The size encoding is 0 byte, 1 halfword, 2 word, 3 doubleword. With any other size, or with `alg` = 0, equal register numbers are legal.
- R7: Whenever `bad_form` is asserted, `ra_we` is deasserted.
- R8: A plain form never asserts `ra_we` or `bad_form`.
- R9: `out_valid` follows `in_valid` by exactly one clock. `ra_we` and `bad_form` are low whenever `out_valid` is low.
- R10: After reset, `out_valid`, `ra_we` and `bad_form` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand strobe |
| ra_idx | input | REGW | Base register number |
| rt_idx | input | REGW | Target register number |
| ra_val | input | XLEN | Base register contents |
| rb_val | input | XLEN | Index register contents |
| sh | input | SHW | Index shift field (shift = sh + 1) |
| upd | input | 1 | Write-back form |
| alg | input | 1 | Sign-extending form |
| acc_size | input | 2 | Access size: 0 byte, 1 half, 2 word, 3 double |
| out_valid | output | 1 | Results valid |
| ea | output | XLEN | Effective address |
| ra_we | output | 1 | Base register write request |
| ra_waddr | output | REGW | Base register write number |
| ra_wdata | output | XLEN | Base register write data |
| bad_form | output | 1 | Illegal encoding |

## Verification
The checker watches several properties on every cycle. It checks the one-cycle valid latency and that the flags are quiet without valid. It checks that an illegal form suppresses the write, that plain forms never write or flag, that register-0 write-back forms flag, and that the write number tracks the base register number. It also checks two address identities: a zero index with a register-0 plain base gives zero, and a zero index with a write-back form gives the base value. The full scaled sum for every shift amount, wrap-around, and the exact split of the register-equality rule by size and sign flag can only be confirmed by the bench's sweep, which compares every field against arithmetic expectations.

// File: rtl/agen_pkg.sv
package agen_pkg;

   typedef enum logic [1:0] {
      SZ_BYTE  = 2'd0,
      SZ_HALF  = 2'd1,
      SZ_WORD  = 2'd2,
      SZ_DWORD = 2'd3
   } acc_size_e;

   typedef struct packed {
      logic      upd;
      logic      alg;
      acc_size_e size;
   } form_t;

   localparam int SCALE_MUX = 0;
   localparam int SCALE_LOG = 1;

endpackage

// File: rtl/agen_scale.sv
module agen_scale #(
   parameter int XLEN = 64,
   parameter int SHW  = 2,
   parameter int IMPL = agen_pkg::SCALE_LOG
) (
   input  logic [XLEN-1:0] idx,
   input  logic [SHW-1:0]  sh,
   output logic [XLEN-1:0] scaled
);
   localparam int AMTW  = SHW + 1;
   localparam int NCASE = 1 << SHW;

   if (IMPL == agen_pkg::SCALE_MUX) begin : g_mux
      logic [XLEN-1:0] cand [NCASE];
      for (genvar k = 0; k < NCASE; k++) begin : g_cand
         assign cand[k] = idx << (k + 1);
      end
      assign scaled = cand[sh];
   end else begin : g_log
      logic [AMTW-1:0] amt;
      logic [XLEN-1:0] stage [AMTW+1];
      assign amt      = {1'b0, sh} + AMTW'(1);
      assign stage[0] = idx;
      for (genvar s = 0; s < AMTW; s++) begin : g_stage
         assign stage[s+1] = amt[s] ? (stage[s] << (1 << s)) : stage[s];
      end
      assign scaled = stage[AMTW];
   end

endmodule

// File: rtl/agen_base.sv
module agen_base #(
   parameter int XLEN = 64,
   parameter int REGW = 5
) (
   input  logic            upd,
   input  logic [REGW-1:0] ra_idx,
   input  logic [XLEN-1:0] ra_val,
   output logic [XLEN-1:0] base
);
   logic use_zero;

   always_comb begin
      use_zero = !upd && (ra_idx == '0);
      base     = use_zero ? '0 : ra_val;
   end

endmodule

// File: rtl/agen_legal.sv
module agen_legal #(
   parameter int REGW       = 5,
   parameter bit RT_OVERLAP = 1'b1
) (
   input  agen_pkg::form_t  form,
   input  logic [REGW-1:0]  ra_idx,
   input  logic [REGW-1:0]  rt_idx,
   output logic             bad,
   output logic             we
);
   logic ra_zero;
   logic overlap_bad;

   assign ra_zero = (ra_idx == '0);

   if (RT_OVERLAP) begin : g_overlap
      assign overlap_bad = form.alg && (form.size == agen_pkg::SZ_HALF)
                           && (ra_idx == rt_idx);
   end else begin : g_no_overlap
      assign overlap_bad = 1'b0;
   end

   always_comb begin
      bad = form.upd && (ra_zero || overlap_bad);
      we  = form.upd && !bad;
   end

endmodule

// File: rtl/idx_scaled_agen.sv
module idx_scaled_agen #(
   parameter int XLEN       = 64,
   parameter int REGW       = 5,
   parameter int SHW        = 2,
   parameter int SCALE_IMPL = agen_pkg::SCALE_LOG
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            in_valid,
   input  logic [REGW-1:0] ra_idx,
   input  logic [REGW-1:0] rt_idx,
   input  logic [XLEN-1:0] ra_val,
   input  logic [XLEN-1:0] rb_val,
   input  logic [SHW-1:0]  sh,
   input  logic            upd,
   input  logic            alg,
   input  logic [1:0]      acc_size,
   output logic            out_valid,
   output logic [XLEN-1:0] ea,
   output logic            ra_we,
   output logic [REGW-1:0] ra_waddr,
   output logic [XLEN-1:0] ra_wdata,
   output logic            bad_form
);
   if (XLEN < 8)  begin : g_chk_xlen  $error("XLEN must be at least 8");  end
   if (REGW < 1)  begin : g_chk_regw  $error("REGW must be at least 1");  end
   if (SHW < 1 || (1 << SHW) >= XLEN) begin : g_chk_shw
      $error("SHW out of range for XLEN");
   end
   if (SCALE_IMPL != agen_pkg::SCALE_MUX && SCALE_IMPL != agen_pkg::SCALE_LOG)
   begin : g_chk_impl
      $error("unknown SCALE_IMPL");
   end

   agen_pkg::form_t form;
   logic [XLEN-1:0] scaled;
   logic [XLEN-1:0] base;
   logic [XLEN-1:0] ea_nxt;
   logic            bad_nxt;
   logic            we_nxt;

   assign form.upd  = upd;
   assign form.alg  = alg;
   assign form.size = agen_pkg::acc_size_e'(acc_size);

   agen_scale #(.XLEN(XLEN), .SHW(SHW), .IMPL(SCALE_IMPL)) i_scale (
      .idx    (rb_val),
      .sh     (sh),
      .scaled (scaled)
   );

   agen_base #(.XLEN(XLEN), .REGW(REGW)) i_base (
      .upd    (upd),
      .ra_idx (ra_idx),
      .ra_val (ra_val),
      .base   (base)
   );

   agen_legal #(.REGW(REGW), .RT_OVERLAP(1'b1)) i_legal (
      .form   (form),
      .ra_idx (ra_idx),
      .rt_idx (rt_idx),
      .bad    (bad_nxt),
      .we     (we_nxt)
   );

   assign ea_nxt = scaled + base;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         ra_we     <= 1'b0;
         bad_form  <= 1'b0;
         ea        <= '0;
         ra_waddr  <= '0;
      end else begin
         out_valid <= in_valid;
         ra_we     <= in_valid && we_nxt;
         bad_form  <= in_valid && bad_nxt;
         if (in_valid) begin
            ea       <= ea_nxt;
            ra_waddr <= ra_idx;
         end
      end
   end

   assign ra_wdata = ea;

endmodule

// File: rtl/agen_chk.sv
module agen_chk #(
   parameter int XLEN = 64,
   parameter int REGW = 5
) (
   input logic            clk,
   input logic            rst_n,
   input logic            in_valid,
   input logic [REGW-1:0] ra_idx,
   input logic [XLEN-1:0] ra_val,
   input logic [XLEN-1:0] rb_val,
   input logic            upd,
   input logic            out_valid,
   input logic [XLEN-1:0] ea,
   input logic            ra_we,
   input logic [REGW-1:0] ra_waddr,
   input logic            bad_form
);
   a_r9_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   a_r9_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
   a_r9_quiet_flags: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> (!ra_we && !bad_form));
   a_r7_bad_blocks_we: assert property (@(posedge clk) disable iff (!rst_n)
      bad_form |-> !ra_we);
   a_r8_plain_silent: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !upd) |=> (!ra_we && !bad_form));
   a_r5_ra0_upd_bad: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && upd && ra_idx == '0) |=> bad_form);
   a_r4_waddr_tracks: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> (ra_waddr == $past(ra_idx)));
   a_r2_zero_base: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !upd && ra_idx == '0 && rb_val == '0) |=> (ea == '0));
   a_r3_upd_base: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && upd && rb_val == '0) |=> (ea == $past(ra_val)));

endmodule

bind idx_scaled_agen agen_chk #(.XLEN(XLEN), .REGW(REGW)) i_agen_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .ra_idx    (ra_idx),
   .ra_val    (ra_val),
   .rb_val    (rb_val),
   .upd       (upd),
   .out_valid (out_valid),
   .ea        (ea),
   .ra_we     (ra_we),
   .ra_waddr  (ra_waddr),
   .bad_form  (bad_form)
);

// File: tb/test_idx_scaled_agen.sv
module test_idx_scaled_agen;
   localparam int CLK_PERIOD = 10;
   localparam int XLEN = 64;
   localparam int REGW = 5;
   localparam int SHW  = 2;
   localparam int WATCHDOG = 50000;
   localparam logic [REGW-1:0] RA_SET [4] = '{5'd0, 5'd1, 5'd5, 5'd31};
   localparam logic [REGW-1:0] RT_SET [3] = '{5'd0, 5'd5, 5'd31};

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            in_valid = 1'b0;
   logic [REGW-1:0] ra_idx = '0;
   logic [REGW-1:0] rt_idx = '0;
   logic [XLEN-1:0] ra_val = '0;
   logic [XLEN-1:0] rb_val = '0;
   logic [SHW-1:0]  sh = '0;
   logic            upd = 1'b0;
   logic            alg = 1'b0;
   logic [1:0]      acc_size = '0;
   logic            out_valid;
   logic [XLEN-1:0] ea;
   logic            ra_we;
   logic [REGW-1:0] ra_waddr;
   logic [XLEN-1:0] ra_wdata;
   logic            bad_form;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 1'b0;
   logic [63:0] seed = 64'h9E37_79B9_7F4A_7C15;

   always #(CLK_PERIOD/2) clk = ~clk;

   idx_scaled_agen #(.XLEN(XLEN), .REGW(REGW), .SHW(SHW)) i_idx_scaled_agen (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .ra_idx(ra_idx),
      .rt_idx(rt_idx), .ra_val(ra_val), .rb_val(rb_val), .sh(sh), .upd(upd),
      .alg(alg), .acc_size(acc_size), .out_valid(out_valid), .ea(ea),
      .ra_we(ra_we), .ra_waddr(ra_waddr), .ra_wdata(ra_wdata),
      .bad_form(bad_form)
   );

   function automatic logic [63:0] next_rand(input logic [63:0] s);
      logic [63:0] x;
      x = s;
      x = x ^ (x << 13);
      x = x ^ (x >> 7);
      x = x ^ (x << 17);
      return x;
   endfunction

   task automatic check(input string req, input logic [63:0] act,
                        input logic [63:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic run_one(input logic [REGW-1:0] a, input logic [REGW-1:0] t,
                          input logic [XLEN-1:0] av, input logic [XLEN-1:0] bv,
                          input logic [SHW-1:0] s, input logic u,
                          input logic g, input logic [1:0] z);
      logic [XLEN-1:0] base_e;
      logic [XLEN-1:0] ea_e;
      logic            bad_e;
      logic            we_e;
      in_valid = 1'b1; ra_idx = a; rt_idx = t; ra_val = av; rb_val = bv;
      sh = s; upd = u; alg = g; acc_size = z;
      // R2/R3: base choice; R1: scaled sum mod 2^64
      base_e = (u || a != '0) ? av : '0;
      ea_e   = (bv << (int'(s) + 1)) + base_e;
      // R5/R6: legality
      bad_e  = u && ((a == '0) || (g && z == 2'd1 && a == t));
      we_e   = u && !bad_e;
      @(negedge clk);
      in_valid = 1'b0;
      check("R9", 64'(out_valid), 64'd1);
      check(u ? "R3" : "R1", ea, ea_e);
      check(u ? "R6" : "R8", 64'(bad_form), 64'(bad_e));
      check(bad_e ? "R7" : "R4", 64'(ra_we), 64'(we_e));
      if (we_e) begin
         check("R4", 64'(ra_waddr), 64'(a));
         check("R4", ra_wdata, ea_e);
      end
   endtask

   task automatic idle_check;
      in_valid = 1'b0;
      @(negedge clk);
      check("R9", 64'(out_valid), 64'd0);
      check("R9", 64'({ra_we, bad_form}), 64'd0);
   endtask

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL R9 watchdog actual=running expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R10: reset state
      check("R10", 64'({out_valid, ra_we, bad_form}), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R10", 64'({out_valid, ra_we, bad_form}), 64'd0);

      // R1: wrap-around of the sum, largest shift
      run_one(5'd3, 5'd4, 64'h20, '1, 2'd3, 1'b0, 1'b0, 2'd0);
      check("R1", ea, 64'h10);
      // R2: register 0 plain base is zero although the value is not
      run_one(5'd0, 5'd4, 64'hDEAD_BEEF, 64'h1, 2'd0, 1'b0, 1'b0, 2'd3);
      check("R2", ea, 64'h2);
      // R3: register 0 write-back uses the value (and is flagged, R5)
      run_one(5'd0, 5'd4, 64'h1000, 64'h1, 2'd1, 1'b1, 1'b0, 2'd0);
      check("R3", ea, 64'h1004);
      check("R5", 64'(bad_form), 64'd1);
      idle_check();

      for (int si = 0; si < 4; si++)
         for (int ui = 0; ui < 2; ui++)
            for (int gi = 0; gi < 2; gi++)
               for (int zi = 0; zi < 4; zi++)
                  for (int ai = 0; ai < 4; ai++)
                     for (int ti = 0; ti < 3; ti++)
                        for (int pi = 0; pi < 2; pi++) begin
                           logic [63:0] va;
                           logic [63:0] vb;
                           seed = next_rand(seed); va = seed;
                           seed = next_rand(seed); vb = seed;
                           run_one(RA_SET[ai], RT_SET[ti], va, vb, SHW'(si),
                                   ui[0], gi[0], zi[1:0]);
                           if (((si + ai + ti + pi) % 7) == 0) idle_check();
                        end

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule